// File: doc/BRIEF.md
# Shift-Register LIFO Stack

This block is a last-in, first-out store built from a chain of registers. The newest word always sits in one fixed register at the head of the chain, so the top-of-stack output needs no address decode and no multiplexer. A push shifts every stored word one place deeper and loads the incoming word at the head. A pop shifts every word one place back toward the head and clears the deepest place.

An occupancy counter drives the full and empty flags. A request that cannot be honoured is rejected: the contents stay as they were, and the error output pulses for one cycle. When push and pop are strobed together on a non-empty stack, the word at the head is swapped for the incoming word and the occupancy does not change. The word width and the depth are parameters.

Top module: `shift_lifo`

## Requirements
- R1: During and right after a synchronous active-low reset, the stack is empty, full is low, the top output reads zero and the error output is low.
- R2: A push alone on a stack that is not full puts the data input on the top output after the next clock edge, raises the occupancy by one, and keeps every older word one place deeper.
- R3: A pop alone on a non-empty stack removes the head word and lowers the occupancy by one. Words come back in the reverse of the order they were pushed.
- R4: A pop clears the deepest place, so the top output reads zero whenever the stack is empty.
- R5: A push alone on a full stack is an overflow. It changes neither the contents nor the flags.
- R6: A pop on an empty stack is an underflow. It changes neither the contents nor the flags.
- R7: Push and pop together on a non-empty stack (including a full one) replace the head word with the data input. The occupancy and the flags stay the same, and no error is raised.
- R8: Push and pop together on an empty stack are rejected as an underflow, and the stack stays empty.
- R9: Full is high exactly when the occupancy equals DEPTH. Empty is high exactly when the occupancy is zero. The two are never high together.
- R10: The error output is high in the cycle after a rejected request and low in the cycle after any request that is accepted, and after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Push strobe, one word per cycle |
| pop | input | 1 | Pop strobe, one word per cycle |
| din | input | DATA_W | Word to push, or the replacement word on a swap |
| top | output | DATA_W | Word at the head of the stack, zero when empty |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| err | output | 1 | One-cycle pulse after a rejected request |

## Verification
Every result here comes from a register: the top word, both flags and the error pulse are all due one rising edge after the strobe that causes them, and none takes any longer. The bench drives each request on a falling edge and holds it across one rising edge. It advances its queue model at that edge and compares all four outputs on the next falling edge, before the following request is applied. Idle cycles are compared in the same way, so a late or stretched error pulse shows up as a mismatch.

// File: rtl/lifo_pkg.sv
// Package lifo_pkg
// Shared types for the shift-register stack: the per-cycle operation that
// the controller decides and every storage place obeys.
package lifo_pkg;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,   // keep every place as it is
        OP_PUSH   = 3'd1,   // shift deeper, load head from input
        OP_POP    = 3'd2,   // shift toward head, clear deepest place
        OP_SWAP   = 3'd3,   // replace head only
        OP_REJECT = 3'd4    // refused request: hold and flag an error
    } lifo_op_e;

endpackage

// File: rtl/lifo_ctrl.sv
// Module lifo_ctrl
// Decodes the push/pop strobes against the current occupancy into one
// operation for the storage chain. Keeps the occupancy count and the
// registered error pulse.
// Assumes: at most one word enters and one leaves per cycle.
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  logic     pop,
    output lifo_op_e op,
    output logic     full,
    output logic     empty,
    output logic     err
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count;

    assign full  = (count == CNT_MAX);
    assign empty = (count == '0);

    // Pick this cycle's operation from the strobes and the occupancy.
    always_comb begin
        op = OP_HOLD;
        if (push && pop)
            op = empty ? OP_REJECT : OP_SWAP;
        else if (push)
            op = full ? OP_REJECT : OP_PUSH;
        else if (pop)
            op = empty ? OP_REJECT : OP_POP;
    end

    // Track the occupancy and register the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            err <= (op == OP_REJECT);
            case (op)
                OP_PUSH: count <= count + 1'b1;
                OP_POP:  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/lifo_cell.sv
// Module lifo_cell
// One storage place of the chain. It takes the shallower neighbour's word
// on a push and the deeper neighbour's word on a pop. The head place
// (IS_HEAD) also loads its shallower input on a swap.
// Assumes: the head's shallower input is the data input, and the deepest
// place's deeper input is tied to zero.
module lifo_cell
    import lifo_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit IS_HEAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lifo_op_e          op,
    input  logic [DATA_W-1:0] from_up,
    input  logic [DATA_W-1:0] from_down,
    output logic [DATA_W-1:0] q
);

    // Update this place according to the chain-wide operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op)
                OP_PUSH: q <= from_up;
                OP_POP:  q <= from_down;
                OP_SWAP: if (IS_HEAD) q <= from_up;
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/shift_lifo.sv
// Module shift_lifo
// Top level of the register-chain stack. Place 0 is the head and always
// drives the top output; higher indices are deeper. There is no pointer:
// the words themselves move through the chain.
// Assumes: DEPTH >= 2.
module shift_lifo
    import lifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] top,
    output logic              full,
    output logic              empty,
    output logic              err
);

    lifo_op_e          op;
    logic [DATA_W-1:0] place [DEPTH];

    lifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .op    (op),
        .full  (full),
        .empty (empty),
        .err   (err)
    );

    // Build the chain: each place links to its shallower and deeper neighbour.
    for (genvar i = 0; i < DEPTH; i++) begin : g_place
        logic [DATA_W-1:0] up_w;
        logic [DATA_W-1:0] down_w;

        if (i == 0) begin : g_head
            assign up_w = din;
        end else begin : g_mid
            assign up_w = place[i-1];
        end

        if (i == DEPTH - 1) begin : g_last
            assign down_w = '0;
        end else begin : g_inner
            assign down_w = place[i+1];
        end

        lifo_cell #(.DATA_W(DATA_W), .IS_HEAD(i == 0)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .op        (op),
            .from_up   (up_w),
            .from_down (down_w),
            .q         (place[i])
        );
    end

    assign top = place[0];

endmodule

// File: rtl/shift_lifo_chk.sv
// Module shift_lifo_chk
// Port-level properties of the stack, bound onto every shift_lifo instance.
module shift_lifo_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push,
    input logic              pop,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] top,
    input logic              full,
    input logic              empty,
    input logic              err
);

    logic refused;
    assign refused = (pop && empty) || (push && !pop && full);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !err && top == '0));

    // R2
    push_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (top == $past(din) && !empty));

    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (top == '0));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (err && full && $stable(top)));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (err && empty));

    // R7
    swap_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty) |=> (top == $past(din) && !err && $stable(full) && $stable(empty)));

    // R8
    swap_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && empty) |=> (err && empty));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !refused |=> !err);

endmodule

bind shift_lifo shift_lifo_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_shift_lifo.sv
`timescale 1ns/1ps
// Bench for shift_lifo: a queue-based model is advanced at each rising edge
// and compared with the outputs at the following falling edge.
module test_shift_lifo;

    localparam int W     = 16;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push = 1'b0;
    logic         pop = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] top;
    logic         full, empty, err;

    int compared = 0;
    int mismatched = 0;
    logic [W-1:0] model [$];
    logic exp_err = 1'b0;

    always #2 clk = ~clk;

    shift_lifo #(.DATA_W(W), .DEPTH(DEPTH)) i_shift_lifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(din),
        .top(top), .full(full), .empty(empty), .err(err)
    );

    task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [W-1:0] exp_top;
        exp_top = (model.size() > 0) ? model[0] : '0;
        chk(tag, "top", top, exp_top);
        chk("R9", "full", W'(full), W'(model.size() == DEPTH));
        chk("R9", "empty", W'(empty), W'(model.size() == 0));
        chk("R10", "err", W'(err), W'(exp_err));
    endtask

    // Apply one request for one cycle, advance the model, compare.
    task automatic step(input logic p, input logic o, input logic [W-1:0] d, input string tag);
        logic rej;
        push = p; pop = o; din = d;
        @(posedge clk);
        rej = (o && model.size() == 0) || (p && !o && model.size() == DEPTH);
        if (!rej) begin
            if (p && o) model[0] = d;
            else if (p) model.push_front(d);
            else if (o) void'(model.pop_front());
        end
        exp_err = rej;
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        compare_all(tag);
    endtask

    initial begin : watchdog
        #(4 * 50000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        step(1'b0, 1'b0, '0, "R1");

        // Underflow on empty, twice in a row, then recovery.
        step(1'b0, 1'b1, '0, "R6");
        step(1'b0, 1'b1, '0, "R6");
        step(1'b0, 1'b0, '0, "R10");
        step(1'b1, 1'b1, 16'hdead, "R8");
        step(1'b0, 1'b0, '0, "R4");

        // Fill to the limit.
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, W'(16'h1000 + i * 16'h0111), "R2");
        step(1'b1, 1'b0, 16'hbad0, "R5");
        step(1'b1, 1'b0, 16'hbad1, "R5");
        step(1'b1, 1'b1, 16'h5a5a, "R7");

        // Drain completely: reverse order, zero at the end.
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, '0, "R3");
        step(1'b0, 1'b1, '0, "R6");
        step(1'b0, 1'b0, '0, "R4");

        // Mixed pattern.
        for (int i = 0; i < 60; i++) begin
            logic p, o;
            p = ((i * 7 + 3) % 5) < 3;
            o = ((i * 11 + 1) % 4) < 2;
            step(p, o, W'(i * 16'h0313 + 16'h0042), (p && o) ? "R7" : (p ? "R2" : "R3"));
        end

        // Reset in mid-stream empties the stack.
        push = 1'b1; din = 16'h7777;
        rst_n = 1'b0;
        @(posedge clk);
        model.delete();
        exp_err = 1'b0;
        @(negedge clk);
        push = 1'b0;
        compare_all("R1");
        rst_n = 1'b1;
        step(1'b1, 1'b0, 16'h0abc, "R2");
        step(1'b0, 1'b1, '0, "R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule